// File: doc/BRIEF.md
# Watchdog Reconfiguration Controller

This block supervises two redundant on-board computers, one active and one held as a cold standby. The active computer's software must feed a watchdog at intervals shorter than a programmable timeout, using a two-value key that alternates with every accepted feed. When the watchdog expires, the block pulses the active computer's reset. After repeated consecutive expiries it first changes the boot image to the fallback image. After more expiries it removes power from the failing unit, powers the standby and brings that unit up on the nominal image. A run of correct feeds long enough to count as healthy clears the failure count.

A ground command can force the active unit and the boot image directly. It takes priority over the automatic policy. Every recovery action is appended, with a timestamp, to a small circular context memory. Computer resets leave this memory intact. Software may also append its own entries, and the whole log can be read back by address.

Top module: `wdg_reconfig_ctrl`

## Requirements
- R1: After block reset, unit 0 is powered (`pwr_en`=01), `active_unit`=0, no computer reset is asserted, `boot_img`=0 (nominal) and `log_head`=0.
- R2: After every restart of the watchdog, the first accepted feed key is KEY_A (0xA5) and the next is KEY_B (0x5A), alternating from then on. A feed whose key does not match the expected value is ignored and does not restart the timer.
- R3: If `cfg_timeout` consecutive running cycles pass without an accepted feed, the active unit's `cpu_rst` bit rises in the next cycle. It stays high for exactly RST_CYCLES cycles. Feeds during that pulse are ignored, and after the pulse the watchdog restarts from zero.
- R4: Each expiry increments a consecutive-failure count n. If n < RETRY_LIMIT, the boot image becomes nominal (0). If RETRY_LIMIT <= n < SWITCH_LIMIT, the boot image becomes fallback (1). When n reaches SWITCH_LIMIT, power moves to the other unit, which becomes active with the nominal image and a reset pulse, and the count clears. Exactly one unit is powered at any time.
- R5: When the number of accepted feeds since the last restart reaches `cfg_healthy`, the failure count clears.
- R6: Each recovery action writes one entry {timestamp, code} at index `log_head` and advances `log_head` by one. The code occupies bits [3:0]: 1 = reset with nominal image, 2 = reset with fallback image, 3 = switch-over, 4 = ground override.
- R7: The log is a circular buffer of 2^LOG_AW entries. `log_head` wraps to 0, the oldest entry is overwritten, and entries survive computer resets.
- R8: A ground command (`gnd_valid`) sets the active unit and boot image from `gnd_unit` and `gnd_img` in the next cycle, resets that unit, clears the failure count and logs code 4. It wins over an expiry in the same cycle, and only one entry is written.
- R9: `sw_log_valid` appends an entry carrying `sw_log_code`. It is dropped if a recovery action is logged in the same cycle.
- R10: The timestamp bits [TS_W+3:4] of an entry equal the number of clock cycles since block reset release, counted at the cycle in which the action was taken (the first cycle is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cfg_timeout | input | CNT_W | Watchdog expiry period in cycles |
| cfg_healthy | input | CNT_W | Accepted feeds that clear the failure count |
| kick_valid | input | 1 | Feed strobe from the active computer |
| kick_key | input | KEY_W | Feed key value |
| gnd_valid | input | 1 | Ground override command strobe |
| gnd_unit | input | 1 | Unit forced active by the override |
| gnd_img | input | 1 | Boot image forced by the override |
| sw_log_valid | input | 1 | Software log append strobe |
| sw_log_code | input | 4 | Code for a software log entry |
| log_rd_addr | input | LOG_AW | Context memory read index |
| log_rd_data | output | TS_W+4 | Entry at `log_rd_addr` |
| log_head | output | LOG_AW | Index of the next entry to be written |
| pwr_en | output | 2 | Power enable per unit |
| cpu_rst | output | 2 | Reset per unit, active high |
| active_unit | output | 1 | Index of the active unit |
| boot_img | output | 1 | Boot image select, 0 nominal, 1 fallback |

## Verification
The expiry delay is swept over every timeout from 1 to 6 from a clean reset. Each trip cycle and each logged timestamp is compared with the value computed from the timeout. Feed streams with correct alternating keys keep the unit alive. A stream of repeated wrong keys must not delay the expiry by even one cycle, and feeds sent during the reset pulse must not shift the key sequence. Uninterrupted failures walk the escalation ladder through nominal retry, fallback retry and switch-over. Runs with one fewer feed than the healthy count are distinguished from runs that reach it. Ground commands placed in the exact cycle of an expiry, together with a software append, show priority and single-entry logging. The final sweep over the log confirms the wrap-around.

// File: rtl/wdr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the watchdog reconfiguration controller.
// Assumes the event code field is four bits wide and sits at the low end of a log entry.
package wdr_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        EV_NONE     = 4'd0,
        EV_RESET    = 4'd1,
        EV_FALLBACK = 4'd2,
        EV_SWITCH   = 4'd3,
        EV_GROUND   = 4'd4
    } ev_code_t;

endpackage

// File: rtl/wdr_watchdog.sv
`timescale 1ns/1ps
// Feed filter and expiry timer.
// Accepts a feed only when its key equals the expected alternating value.
// Raises a one-cycle timeout after cfg_timeout running cycles without an accepted feed.
// Raises a healthy pulse after cfg_healthy accepted feeds.
// Assumes run is low while the supervised computer is held in reset; all state clears then.
module wdr_watchdog #(
    parameter int               CNT_W = 16,
    parameter int               KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_A = 'hA5,
    parameter logic [KEY_W-1:0] KEY_B = 'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic [CNT_W-1:0] cfg_healthy,
    input  logic             kick_valid,
    input  logic [KEY_W-1:0] kick_key,
    output logic             timeout,
    output logic             healthy
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] feeds_q;
    logic             want_b_q;
    logic             kick_ok;
    logic             expire;

    // Feed acceptance: key must match the value expected next
    assign kick_ok = run && kick_valid && (kick_key == (want_b_q ? KEY_B : KEY_A));

    // Expiry when this cycle is the last one allowed by the timeout
    assign expire  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cfg_timeout};
    assign timeout = run && !kick_ok && expire;
    assign healthy = kick_ok && (({1'b0, feeds_q} + 1'b1) >= {1'b0, cfg_healthy});

    // Timer, key phase and healthy feed counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q    <= '0;
            feeds_q  <= '0;
            want_b_q <= 1'b0;
        end else if (kick_ok) begin
            cnt_q    <= '0;
            want_b_q <= ~want_b_q;
            feeds_q  <= healthy ? '0 : feeds_q + 1'b1;
        end else if (expire) begin
            cnt_q    <= '0;
            feeds_q  <= '0;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdr_policy.sv
`timescale 1ns/1ps
// Recovery policy: failure counting, boot image choice, switch-over and reset pulse.
// A ground command overrides the automatic decision in the same cycle.
// Assumes RETRY_LIMIT <= SWITCH_LIMIT and RST_CYCLES >= 1.
module wdr_policy
    import wdr_pkg::*;
#(
    parameter int RETRY_LIMIT  = 2,
    parameter int SWITCH_LIMIT = 4,
    parameter int RST_CYCLES   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timeout,
    input  logic       healthy,
    input  logic       gnd_valid,
    input  logic       gnd_unit,
    input  logic       gnd_img,
    output logic       run,
    output logic       active_unit,
    output logic       boot_img,
    output logic [1:0] pwr_en,
    output logic [1:0] cpu_rst,
    output logic       ev_valid,
    output ev_code_t   ev_code
);

    localparam int           FW    = $clog2(SWITCH_LIMIT + 1);
    localparam int           HW    = $clog2(RST_CYCLES + 1);
    localparam logic [FW:0]  LIM_R = RETRY_LIMIT[FW:0];
    localparam logic [FW:0]  LIM_S = SWITCH_LIMIT[FW:0];
    localparam logic [HW-1:0] HOLD = RST_CYCLES[HW-1:0];

    logic          act_q,  act_d;
    logic          img_q,  img_d;
    logic [FW-1:0] fail_q, fail_d;
    logic [HW-1:0] hold_q, hold_d;
    logic [FW:0]   tries;

    assign tries = {1'b0, fail_q} + 1'b1;

    // Next-state decision with override above expiry above healthy clear
    always_comb begin
        act_d    = act_q;
        img_d    = img_q;
        fail_d   = fail_q;
        hold_d   = (hold_q != '0) ? hold_q - 1'b1 : '0;
        ev_valid = 1'b0;
        ev_code  = EV_NONE;
        if (gnd_valid) begin
            act_d    = gnd_unit;
            img_d    = gnd_img;
            fail_d   = '0;
            hold_d   = HOLD;
            ev_valid = 1'b1;
            ev_code  = EV_GROUND;
        end else if (timeout) begin
            hold_d   = HOLD;
            ev_valid = 1'b1;
            if (tries >= LIM_S) begin
                act_d   = ~act_q;
                img_d   = 1'b0;
                fail_d  = '0;
                ev_code = EV_SWITCH;
            end else if (tries >= LIM_R) begin
                img_d   = 1'b1;
                fail_d  = tries[FW-1:0];
                ev_code = EV_FALLBACK;
            end else begin
                img_d   = 1'b0;
                fail_d  = tries[FW-1:0];
                ev_code = EV_RESET;
            end
        end else if (healthy) begin
            fail_d = '0;
        end
    end

    // Policy state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            img_q  <= 1'b0;
            fail_q <= '0;
            hold_q <= '0;
        end else begin
            act_q  <= act_d;
            img_q  <= img_d;
            fail_q <= fail_d;
            hold_q <= hold_d;
        end
    end

    assign run         = (hold_q == '0);
    assign active_unit = act_q;
    assign boot_img    = img_q;

    // Per-unit power and reset outputs
    for (genvar u = 0; u < 2; u++) begin : g_unit
        assign pwr_en[u]  = (act_q == u[0]);
        assign cpu_rst[u] = (act_q == u[0]) && !run;
    end

endmodule

// File: rtl/wdr_ctx_log.sv
`timescale 1ns/1ps
// Circular context memory with a free-running timestamp.
// Hardware events take the write slot over software appends in the same cycle.
// Assumes the array itself is never cleared; only the head pointer and time reset.
module wdr_ctx_log
    import wdr_pkg::*;
#(
    parameter int LOG_AW = 4,
    parameter int TS_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_valid,
    input  ev_code_t               hw_code,
    input  logic                   sw_valid,
    input  logic [CODE_W-1:0]      sw_code,
    input  logic [LOG_AW-1:0]      rd_addr,
    output logic [TS_W+CODE_W-1:0] rd_data,
    output logic [LOG_AW-1:0]      head
);

    localparam int DEPTH = 1 << LOG_AW;
    localparam int ENT_W = TS_W + CODE_W;

    logic [ENT_W-1:0]  mem [DEPTH];
    logic [TS_W-1:0]   ts_q;
    logic [LOG_AW-1:0] head_q;
    logic              wr_en;
    logic [CODE_W-1:0] wr_code;

    assign wr_en   = hw_valid || sw_valid;
    assign wr_code = hw_valid ? hw_code : sw_code;

    // Timestamp and write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q   <= '0;
            head_q <= '0;
        end else begin
            ts_q <= ts_q + 1'b1;
            if (wr_en) head_q <= head_q + 1'b1;
        end
    end

    // Entry storage, deliberately without reset
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) mem[head_q] <= {ts_q, wr_code};
    end

    assign rd_data = mem[rd_addr];
    assign head    = head_q;

endmodule

// File: rtl/wdg_reconfig_ctrl.sv
`timescale 1ns/1ps
// Top level: watchdog, recovery policy and context log for a redundant computer pair.
// Assumes inputs are synchronous to clk and the override strobe lasts one cycle per command.
module wdg_reconfig_ctrl
    import wdr_pkg::*;
#(
    parameter int               CNT_W        = 16,
    parameter int               KEY_W        = 8,
    parameter logic [KEY_W-1:0] KEY_A        = 'hA5,
    parameter logic [KEY_W-1:0] KEY_B        = 'h5A,
    parameter int               RETRY_LIMIT  = 2,
    parameter int               SWITCH_LIMIT = 4,
    parameter int               RST_CYCLES   = 8,
    parameter int               LOG_AW       = 4,
    parameter int               TS_W         = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       cfg_timeout,
    input  logic [CNT_W-1:0]       cfg_healthy,
    input  logic                   kick_valid,
    input  logic [KEY_W-1:0]       kick_key,
    input  logic                   gnd_valid,
    input  logic                   gnd_unit,
    input  logic                   gnd_img,
    input  logic                   sw_log_valid,
    input  logic [CODE_W-1:0]      sw_log_code,
    input  logic [LOG_AW-1:0]      log_rd_addr,
    output logic [TS_W+CODE_W-1:0] log_rd_data,
    output logic [LOG_AW-1:0]      log_head,
    output logic [1:0]             pwr_en,
    output logic [1:0]             cpu_rst,
    output logic                   active_unit,
    output logic                   boot_img
);

    logic     run;
    logic     wd_timeout;
    logic     wd_healthy;
    logic     ev_valid;
    ev_code_t ev_code;

    wdr_watchdog #(
        .CNT_W (CNT_W),
        .KEY_W (KEY_W),
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) u_wd (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cfg_timeout (cfg_timeout),
        .cfg_healthy (cfg_healthy),
        .kick_valid  (kick_valid),
        .kick_key    (kick_key),
        .timeout     (wd_timeout),
        .healthy     (wd_healthy)
    );

    wdr_policy #(
        .RETRY_LIMIT  (RETRY_LIMIT),
        .SWITCH_LIMIT (SWITCH_LIMIT),
        .RST_CYCLES   (RST_CYCLES)
    ) u_pol (
        .clk         (clk),
        .rst_n       (rst_n),
        .timeout     (wd_timeout),
        .healthy     (wd_healthy),
        .gnd_valid   (gnd_valid),
        .gnd_unit    (gnd_unit),
        .gnd_img     (gnd_img),
        .run         (run),
        .active_unit (active_unit),
        .boot_img    (boot_img),
        .pwr_en      (pwr_en),
        .cpu_rst     (cpu_rst),
        .ev_valid    (ev_valid),
        .ev_code     (ev_code)
    );

    wdr_ctx_log #(
        .LOG_AW (LOG_AW),
        .TS_W   (TS_W)
    ) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_valid (ev_valid),
        .hw_code  (ev_code),
        .sw_valid (sw_log_valid),
        .sw_code  (sw_log_code),
        .rd_addr  (log_rd_addr),
        .rd_data  (log_rd_data),
        .head     (log_head)
    );

endmodule

// File: rtl/wdr_checker.sv
`timescale 1ns/1ps
// Temporal checks on the controller's outputs and its watchdog-to-policy handoff.
// Assumes one ground command or expiry is handled per cycle.
module wdr_checker #(
    parameter int LOG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wd_timeout,
    input logic              gnd_valid,
    input logic              gnd_unit,
    input logic              gnd_img,
    input logic              sw_log_valid,
    input logic [1:0]        pwr_en,
    input logic [1:0]        cpu_rst,
    input logic              boot_img,
    input logic [LOG_AW-1:0] log_head
);

    // Exactly one unit is powered (R4)
    p_single_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwr_en) == 1);

    // Reset only ever reaches the powered unit (R3)
    p_rst_on_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst & ~pwr_en) == 2'b00);

    // An expiry is followed by a reset of the unit that is then active (R3)
    p_trip_resets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> (cpu_rst == pwr_en));

    // Ground command sets unit and image one cycle later (R8)
    p_ground_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gnd_valid |=> (pwr_en == ($past(gnd_unit) ? 2'b10 : 2'b01))
                      && (boot_img == $past(gnd_img)) && (cpu_rst == pwr_en));

    // Any write source advances the head by exactly one (R6)
    p_log_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_timeout || gnd_valid || sw_log_valid) |=> (log_head == $past(log_head) + 1'b1));

    // Without a write source the head holds (R9)
    p_log_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_timeout || gnd_valid || sw_log_valid) |=> $stable(log_head));

endmodule

bind wdg_reconfig_ctrl wdr_checker #(.LOG_AW(LOG_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wd_timeout   (wd_timeout),
    .gnd_valid    (gnd_valid),
    .gnd_unit     (gnd_unit),
    .gnd_img      (gnd_img),
    .sw_log_valid (sw_log_valid),
    .pwr_en       (pwr_en),
    .cpu_rst      (cpu_rst),
    .boot_img     (boot_img),
    .log_head     (log_head)
);

// File: tb/wdg_reconfig_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: small configuration, timeout sweep, escalation ladder, override and log checks.
module wdg_reconfig_ctrl_tb;

    localparam int         CW  = 8;
    localparam int         RC  = 3;
    localparam int         AW  = 3;
    localparam int         TSW = 16;
    localparam logic [7:0] KA  = 8'hA5;
    localparam logic [7:0] KB  = 8'h5A;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   cfg_timeout = 8'd4;
    logic [CW-1:0]   cfg_healthy = 8'd50;
    logic            kick_valid = 1'b0;
    logic [7:0]      kick_key = 8'h00;
    logic            gnd_valid = 1'b0;
    logic            gnd_unit = 1'b0;
    logic            gnd_img = 1'b0;
    logic            sw_log_valid = 1'b0;
    logic [3:0]      sw_log_code = 4'h0;
    logic [AW-1:0]   log_rd_addr = '0;
    logic [TSW+3:0]  log_rd_data;
    logic [AW-1:0]   log_head;
    logic [1:0]      pwr_en;
    logic [1:0]      cpu_rst;
    logic            active_unit;
    logic            boot_img;

    int n_chk = 0;
    int n_err = 0;
    int bc;
    int exp_head = 0;
    logic [TSW+3:0] exp_mem [8];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bc <= 0;
        else        bc <= bc + 1;
    end

    wdg_reconfig_ctrl #(
        .CNT_W(CW), .KEY_W(8), .KEY_A(KA), .KEY_B(KB),
        .RETRY_LIMIT(2), .SWITCH_LIMIT(3), .RST_CYCLES(RC),
        .LOG_AW(AW), .TS_W(TSW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout), .cfg_healthy(cfg_healthy),
        .kick_valid(kick_valid), .kick_key(kick_key), .gnd_valid(gnd_valid),
        .gnd_unit(gnd_unit), .gnd_img(gnd_img), .sw_log_valid(sw_log_valid),
        .sw_log_code(sw_log_code), .log_rd_addr(log_rd_addr), .log_rd_data(log_rd_data),
        .log_head(log_head), .pwr_en(pwr_en), .cpu_rst(cpu_rst),
        .active_unit(active_unit), .boot_img(boot_img)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input int t);
        rst_n = 1'b0;
        cfg_timeout = t[CW-1:0];
        repeat (3) step();
        rst_n = 1'b1;
        exp_head = 0;
    endtask

    task automatic check_entry(input int idx, input string req);
        log_rd_addr = idx[AW-1:0];
        #1;
        chk(req, "log entry", {12'h0, log_rd_data}, {12'h0, exp_mem[idx]});
    endtask

    task automatic log_expect(input int ts, input logic [3:0] code);
        exp_mem[exp_head] = {ts[TSW-1:0], code};
        check_entry(exp_head, "R6 R10");
        exp_head = (exp_head + 1) % 8;
        chk("R6", "log head", {29'h0, log_head}, exp_head);
    endtask

    task automatic kick(input logic [7:0] key);
        kick_valid = 1'b1;
        kick_key = key;
        step();
        kick_valid = 1'b0;
    endtask

    task automatic expect_trip(input int d, input bit unit, input logic [3:0] code,
                               input bit img, input bit ham, input logic [7:0] hkey);
        logic [1:0] oh;
        oh = unit ? 2'b10 : 2'b01;
        kick_valid = ham;
        kick_key = hkey;
        for (int i = 1; i < d; i++) begin
            step();
            chk("R3", "no early reset", cpu_rst, 2'b00);
        end
        step();
        kick_valid = 1'b0;
        chk("R3", "reset on active unit", cpu_rst, oh);
        chk("R4", "powered unit", pwr_en, oh);
        chk("R4", "boot image", boot_img, img);
        log_expect(bc - 1, code);
    endtask

    task automatic release_rst(input bit hold_kicks);
        kick_valid = hold_kicks;
        kick_key = KA;
        for (int i = 1; i < RC; i++) begin
            step();
            chk("R3", "pulse held", {31'h0, |cpu_rst}, 1);
        end
        step();
        kick_valid = 1'b0;
        chk("R3", "pulse ends", cpu_rst, 2'b00);
    endtask

    initial begin
        #(5.0 * 20000);
        n_err++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R3 sweep of expiry period, with reset state (R1) each time
        for (int t = 1; t <= 6; t++) begin
            cfg_healthy = 8'd50;
            do_reset(t);
            chk("R1", "power after reset", pwr_en, 2'b01);
            chk("R1", "no reset after reset", cpu_rst, 2'b00);
            chk("R1", "image after reset", boot_img, 0);
            chk("R1", "active after reset", active_unit, 0);
            chk("R1", "head after reset", log_head, 0);
            expect_trip(t, 1'b0, 4'd1, 1'b0, 1'b0, 8'h00);
            release_rst(1'b0);
        end

        // R2 alternating keys keep the unit alive, wrong keys do not
        do_reset(6);
        for (int i = 0; i < 8; i++) begin
            if (i > 0) begin
                repeat (3) step();
                chk("R2", "alive while fed", cpu_rst, 2'b00);
            end
            kick((i % 2) ? KB : KA);
        end
        expect_trip(6, 1'b0, 4'd1, 1'b0, 1'b1, KB);
        // R3 feeds during the pulse are ignored: KA is still the expected key
        release_rst(1'b1);
        kick(KA);
        expect_trip(6, 1'b0, 4'd2, 1'b1, 1'b0, 8'h00);
        release_rst(1'b0);

        // R4 escalation ladder, then R5 healthy clearing
        cfg_healthy = 8'd3;
        do_reset(4);
        expect_trip(4, 1'b0, 4'd1, 1'b0, 1'b0, 8'h00); release_rst(1'b0);
        expect_trip(4, 1'b0, 4'd2, 1'b1, 1'b0, 8'h00); release_rst(1'b0);
        expect_trip(4, 1'b1, 4'd3, 1'b0, 1'b0, 8'h00); release_rst(1'b0);
        chk("R4", "standby now active", active_unit, 1);
        expect_trip(4, 1'b1, 4'd1, 1'b0, 1'b0, 8'h00); release_rst(1'b0);
        kick(KA); kick(KB);
        expect_trip(4, 1'b1, 4'd2, 1'b1, 1'b0, 8'h00); release_rst(1'b0);
        kick(KA); kick(KB); kick(KA);
        // R5: third feed cleared the count, so this is a first failure
        expect_trip(4, 1'b1, 4'd1, 1'b0, 1'b0, 8'h00); release_rst(1'b0);

        // R8 override in the expiry cycle, with a colliding software append (R9)
        repeat (3) step();
        gnd_valid = 1'b1; gnd_unit = 1'b0; gnd_img = 1'b1;
        sw_log_valid = 1'b1; sw_log_code = 4'h9;
        step();
        gnd_valid = 1'b0; sw_log_valid = 1'b0;
        chk("R8", "override power", pwr_en, 2'b01);
        chk("R8", "override reset", cpu_rst, 2'b01);
        chk("R8", "override image", boot_img, 1);
        chk("R8", "override active", active_unit, 0);
        log_expect(bc - 1, 4'd4);
        release_rst(1'b0);
        expect_trip(4, 1'b0, 4'd1, 1'b0, 1'b0, 8'h00);
        release_rst(1'b0);

        // R9 software append on its own
        sw_log_valid = 1'b1; sw_log_code = 4'hC;
        step();
        sw_log_valid = 1'b0;
        log_expect(bc - 1, 4'hC);

        // R7 wrap: nine entries in eight slots, older ones survived computer resets
        chk("R7", "head wrapped", log_head, 1);
        for (int i = 0; i < 8; i++) check_entry(i, "R7");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule